// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block performs one bus cycle at a time on an 8-bit multiplexed NAND flash interface. The single IO bus carries commands, addresses and data, and the block distinguishes them only through the two latch-enable lines. A sequencer hands the block one cycle request over a valid/ready handshake. The request names the cycle kind and, for outgoing kinds, the byte to drive. The block then plays out the pin waveform in three phases whose lengths are counted in system clocks. The latch lines come up first. The write or read strobe is then pulsed low. The strobe is released while the latch lines stay where they are for the last phase. Any phase length programmed as 0 lasts one clock.

For a read cycle the block releases the IO bus and pulses the read strobe. It captures the incoming byte on the last clock edge of the strobe pulse and returns the byte on a valid/ready response channel. Back-pressure works as follows. The request side is ready only while the block is idle. While a response waits for its consumer, no new request is accepted, and the response byte holds steady until it is taken. Phase lengths are captured when a request is accepted, so they may be reprogrammed at any time.

The block also brings the asynchronous ready/busy pin through a two-flop synchroniser. It provides the synchronised level and a sticky flag that records each busy-to-ready transition. The flag is cleared by a one-cycle clear pulse. A transition that coincides with a clear still leaves the flag set.

Top module: `nand_cycle_engine`

## Requirements
- R1: Out of reset, and whenever no cycle is in progress and no response is pending, req_ready is 1, nand_cle and nand_ale are 0, nand_we_n and nand_re_n are 1, nand_io_oe is 0, rsp_valid is 0 and rb_rise_flag is 0. req_ready is 0 in every other clock, and a request is taken only on an edge where req_valid and req_ready are both 1.
- R2: req_kind encodes the cycle kind: 0 is command, 1 is address, 2 is write data, 3 is read data. From the clock after acceptance until the hold phase ends, nand_cle is 1 only for kind 0 and nand_ale is 1 only for kind 1. The two are never 1 together.
- R3: The setup phase follows acceptance directly and lasts max(cfg_setup,1) clocks. During it the latch lines are valid and both strobes are high.
- R4: The strobe phase lasts max(cfg_strobe,1) clocks. During it nand_we_n is low for kinds 0 to 2 and nand_re_n is low for kind 3. The two strobes are never low together.
- R5: The hold phase lasts max(cfg_hold,1) clocks, with both strobes high and the latch lines unchanged. For kinds 0 to 2, req_ready is 1 again in the clock right after the hold phase.
- R6: For kinds 0 to 2, nand_io_oe is 1 and nand_io_out equals the accepted req_byte through all three phases. For kind 3, nand_io_oe is 0 throughout.
- R7: For kind 3, rsp_byte is the value of nand_io_in at the clock edge that ends the strobe phase. rsp_valid is 1 from the clock right after the hold phase.
- R8: While rsp_valid is 1 and rsp_ready is 0, rsp_valid and rsp_byte hold and req_ready stays 0. The edge with rsp_ready 1 retires the response and returns the block to idle.
- R9: Phase lengths are taken from cfg_setup, cfg_strobe and cfg_hold on the accepting edge. Changes to those inputs during a cycle have no effect on that cycle.
- R10: rb_level follows nand_rb through two clocked stages, so a change set up before edge n shows on rb_level after edge n+1.
- R11: rb_rise_flag becomes 1 on the edge after rb_level goes from 0 to 1. It stays 1 until cleared. A 1-to-0 change of rb_level does not set it.
- R12: rb_flag_clr at 1 for one edge clears rb_rise_flag. If a rising rb_level is seen in that same clock, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_setup | input | PHASE_W | Clocks from latch lines valid to strobe low (0 means 1) |
| cfg_strobe | input | PHASE_W | Strobe low width in clocks (0 means 1) |
| cfg_hold | input | PHASE_W | Clocks from strobe high to latch lines released (0 means 1) |
| req_valid | input | 1 | Cycle request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_kind | input | 2 | 0 command, 1 address, 2 write data, 3 read data |
| req_byte | input | BUS_W | Byte to drive for kinds 0 to 2 |
| rsp_valid | output | 1 | Read byte available |
| rsp_ready | input | 1 | Consumer takes the read byte |
| rsp_byte | output | BUS_W | Byte captured by a read cycle |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | BUS_W | IO bus drive value |
| nand_io_oe | output | 1 | IO bus drive enable (0 releases the bus) |
| nand_io_in | input | BUS_W | IO bus sampled value |
| nand_rb | input | 1 | Asynchronous ready/busy pin, 1 means ready |
| rb_level | output | 1 | Synchronised ready/busy level |
| rb_rise_flag | output | 1 | Sticky busy-to-ready flag |
| rb_flag_clr | input | 1 | Clears the sticky flag |

## Verification
Counting from the accepting edge, clocks 1 to S are setup, S+1 to S+W are strobe and S+W+1 to S+W+H are hold, where S, W and H are the effective phase lengths. Clock S+W+H+1 shows req_ready again, or rsp_valid for a read, and rsp_byte carries the IO value driven during clock S+W. The bench drives a distinct IO value in every clock and sweeps all setup, strobe and hold values from 0 to 3 across all four kinds. It scrambles the configuration inputs right after each acceptance and samples every pin at the negative edge of each numbered clock against this schedule. The ready/busy checks count two edges to rb_level and a third to the flag, including a clear pulse placed in the same clock as a rise.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_WDATA = 2'd2,
    KIND_RDATA = 2'd3
  } bus_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RESP
  } cyc_state_e;

  typedef struct packed {
    logic cle;
    logic ale;
    logic we_n;
    logic re_n;
    logic oe;
  } pin_set_t;

endpackage

// File: rtl/nbc_phase_timer.sv
// Counts clocks inside the current phase; zero-length phases last one clock.
module nbc_phase_timer #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [PW-1:0] len,
  output logic          last
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;

  assign lim  = (len == '0) ? ONE : len;
  assign last = (cnt_q == lim - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/nbc_pin_decode.sv
// Maps cycle state and kind onto the bus control pins.
module nbc_pin_decode
  import nbc_pkg::*;
(
  input  cyc_state_e st,
  input  bus_kind_e  kind,
  output pin_set_t   pins
);
  logic active;
  logic strobing;

  assign active   = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
  assign strobing = (st == ST_STROBE);

  always_comb begin
    pins.cle  = active && (kind == KIND_CMD);
    pins.ale  = active && (kind == KIND_ADDR);
    pins.we_n = !(strobing && (kind != KIND_RDATA));
    pins.re_n = !(strobing && (kind == KIND_RDATA));
    pins.oe   = active && (kind != KIND_RDATA);
  end
endmodule

// File: rtl/nbc_rb_monitor.sv
// Ready/busy synchroniser with sticky rise flag (set wins over clear).
module nbc_rb_monitor #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  input  logic clr,
  output logic level,
  output logic rise_flag
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              flag_q;
  logic              rise_now;

  assign level     = sync_q[STAGES-1];
  assign rise_now  = level && !prev_q;
  assign rise_flag = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], rb_async};
      prev_q <= level;
      flag_q <= rise_now || (flag_q && !clr);
    end
  end
endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
  import nbc_pkg::*;
#(
  parameter int PHASE_W        = 4,
  parameter int BUS_W          = 8,
  parameter int RB_SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] cfg_setup,
  input  logic [PHASE_W-1:0] cfg_strobe,
  input  logic [PHASE_W-1:0] cfg_hold,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic [BUS_W-1:0]   req_byte,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [BUS_W-1:0]   rsp_byte,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic [BUS_W-1:0]   nand_io_out,
  output logic               nand_io_oe,
  input  logic [BUS_W-1:0]   nand_io_in,
  input  logic               nand_rb,
  output logic               rb_level,
  output logic               rb_rise_flag,
  input  logic               rb_flag_clr
);

  cyc_state_e         st_q, st_d;
  bus_kind_e          kind_q;
  logic [BUS_W-1:0]   byte_q;
  logic [BUS_W-1:0]   rdat_q;
  logic [PHASE_W-1:0] setup_q, strobe_q, hold_q;
  logic [PHASE_W-1:0] phase_len;
  logic               phase_last;
  logic               phase_restart;
  logic               accept;
  logic               is_read;
  pin_set_t           pins;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign is_read   = (kind_q == KIND_RDATA);

  // Length of the phase currently running (captured at acceptance)
  always_comb begin
    case (st_q)
      ST_SETUP:  phase_len = setup_q;
      ST_STROBE: phase_len = strobe_q;
      default:   phase_len = hold_q;
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (accept)     st_d = ST_SETUP;
      ST_SETUP:  if (phase_last) st_d = ST_STROBE;
      ST_STROBE: if (phase_last) st_d = ST_HOLD;
      ST_HOLD:   if (phase_last) st_d = is_read ? ST_RESP : ST_IDLE;
      ST_RESP:   if (rsp_ready)  st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  assign phase_restart = (st_d != st_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      kind_q   <= KIND_CMD;
      byte_q   <= '0;
      rdat_q   <= '0;
      setup_q  <= '0;
      strobe_q <= '0;
      hold_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        kind_q   <= bus_kind_e'(req_kind);
        byte_q   <= req_byte;
        setup_q  <= cfg_setup;
        strobe_q <= cfg_strobe;
        hold_q   <= cfg_hold;
      end
      // Capture on the edge that ends the read strobe
      if ((st_q == ST_STROBE) && phase_last && is_read)
        rdat_q <= nand_io_in;
    end
  end

  nbc_phase_timer #(.PW(PHASE_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (phase_restart),
    .len     (phase_len),
    .last    (phase_last)
  );

  nbc_pin_decode u_pins (
    .st   (st_q),
    .kind (kind_q),
    .pins (pins)
  );

  nbc_rb_monitor #(.STAGES(RB_SYNC_STAGES)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rb_async  (nand_rb),
    .clr       (rb_flag_clr),
    .level     (rb_level),
    .rise_flag (rb_rise_flag)
  );

  assign nand_cle    = pins.cle;
  assign nand_ale    = pins.ale;
  assign nand_we_n   = pins.we_n;
  assign nand_re_n   = pins.re_n;
  assign nand_io_oe  = pins.oe;
  assign nand_io_out = byte_q;
  assign rsp_valid   = (st_q == ST_RESP);
  assign rsp_byte    = rdat_q;

endmodule

// File: rtl/nbc_checker.sv
module nbc_checker #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [BUS_W-1:0] rsp_byte,
  input logic             nand_cle,
  input logic             nand_ale,
  input logic             nand_we_n,
  input logic             nand_re_n,
  input logic             nand_io_oe,
  input logic             rb_level,
  input logic             rb_rise_flag,
  input logic             rb_flag_clr
);

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe));

  p_latch_mutex_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nand_we_n) || $rose(nand_re_n)) |-> ($stable(nand_cle) && $stable(nand_ale)));

  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));

  p_no_accept_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_level) |=> rb_rise_flag);

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_rise_flag && !rb_flag_clr) |=> rb_rise_flag);

  p_fall_no_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rb_level) && !rb_rise_flag) |=> !rb_rise_flag);

  p_flag_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_flag_clr && !$rose(rb_level)) |=> !rb_rise_flag);

endmodule

bind nand_cycle_engine nbc_checker #(.BUS_W(BUS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_byte     (rsp_byte),
  .nand_cle     (nand_cle),
  .nand_ale     (nand_ale),
  .nand_we_n    (nand_we_n),
  .nand_re_n    (nand_re_n),
  .nand_io_oe   (nand_io_oe),
  .rb_level     (rb_level),
  .rb_rise_flag (rb_rise_flag),
  .rb_flag_clr  (rb_flag_clr)
);

// File: tb/sim_nand_cycle_engine.sv
`timescale 1ns/1ps
module sim_nand_cycle_engine;
  localparam int PW = 4;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = '0;
  logic [BW-1:0] req_byte = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [BW-1:0] rsp_byte;
  logic          nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [BW-1:0] nand_io_out;
  logic [BW-1:0] nand_io_in = '0;
  logic          nand_rb = 1'b1;
  logic          rb_level, rb_rise_flag;
  logic          rb_flag_clr = 1'b0;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nand_cycle_engine #(.PHASE_W(PW), .BUS_W(BW), .RB_SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_byte(req_byte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_rb(nand_rb), .rb_level(rb_level), .rb_rise_flag(rb_rise_flag), .rb_flag_clr(rb_flag_clr)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] pat(input int i, input logic [BW-1:0] b);
    return BW'(i * 37) ^ b;
  endfunction

  // One bus cycle; S/W/H effective lengths; pins sampled at negedge of each numbered clock
  task automatic run_cycle(input int k, input logic [BW-1:0] b, input int s, input int w, input int h);
    int es, ew, eh, total;
    int bad_s, bad_w, bad_h, bad_l, bad_io, bad_r;
    bit strobe, exp_we, exp_re;
    es = (s == 0) ? 1 : s;
    ew = (w == 0) ? 1 : w;
    eh = (h == 0) ? 1 : h;
    total = es + ew + eh;
    bad_s = 0; bad_w = 0; bad_h = 0; bad_l = 0; bad_io = 0; bad_r = 0;
    @(negedge clk);
    cfg_setup = PW'(s); cfg_strobe = PW'(w); cfg_hold = PW'(h);
    req_kind = 2'(k); req_byte = b; req_valid = 1'b1;
    check(req_ready === 1'b1, "R1", "req_ready idle before request", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    // R9: scramble phase inputs after acceptance
    cfg_setup = PW'(15 - s); cfg_strobe = PW'(14 - w); cfg_hold = PW'(13 - h);
    req_byte = ~b;
    for (int i = 1; i <= total; i++) begin
      if (i > 1) @(negedge clk);
      strobe = (i > es) && (i <= es + ew);
      exp_we = !(strobe && k != 3);
      exp_re = !(strobe && k == 3);
      if (nand_we_n !== exp_we || nand_re_n !== exp_re) begin
        if (i <= es) bad_s++;
        else if (strobe) bad_w++;
        else bad_h++;
      end
      if (nand_cle !== (k == 0) || nand_ale !== (k == 1)) bad_l++;
      if (nand_io_oe !== (k != 3) || (k != 3 && nand_io_out !== b)) bad_io++;
      if (req_ready !== 1'b0 || rsp_valid !== 1'b0) bad_r++;
      nand_io_in = pat(i, b);
    end
    check(bad_s == 0, "R3", "setup-phase strobe mismatches (R9 scrambled cfg)", bad_s, 0);
    check(bad_w == 0, "R4", "strobe-phase mismatches (R9 scrambled cfg)", bad_w, 0);
    check(bad_h == 0, "R5", "hold-phase strobe mismatches", bad_h, 0);
    check(bad_l == 0, "R2", "latch line mismatches", bad_l, 0);
    check(bad_io == 0, "R6", "IO drive mismatches", bad_io, 0);
    check(bad_r == 0, "R1", "req_ready/rsp_valid during cycle", bad_r, 0);
    @(negedge clk); // clock total+1
    if (k == 3) begin
      check(rsp_valid === 1'b1 && req_ready === 1'b0, "R7", "rsp_valid after hold", int'(rsp_valid), 1);
      check(rsp_byte === pat(es + ew, b), "R7", "read byte at strobe end", int'(rsp_byte), int'(pat(es + ew, b)));
      for (int j = 0; j < h; j++) begin
        nand_io_in = ~nand_io_in;
        @(negedge clk);
        check(rsp_valid === 1'b1 && req_ready === 1'b0 && rsp_byte === pat(es + ew, b),
              "R8", "response held under back-pressure", int'(rsp_byte), int'(pat(es + ew, b)));
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check(rsp_valid === 1'b0 && req_ready === 1'b1, "R8", "response retired", int'(req_ready), 1);
    end else begin
      check(req_ready === 1'b1, "R5", "req_ready right after hold", int'(req_ready), 1);
      check(nand_cle === 1'b0 && nand_ale === 1'b0 && nand_io_oe === 1'b0, "R1", "idle pins after cycle",
            int'({nand_cle, nand_ale, nand_io_oe}), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(req_ready === 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    check(nand_cle === 1'b0 && nand_ale === 1'b0 && nand_we_n === 1'b1 && nand_re_n === 1'b1 && nand_io_oe === 1'b0,
          "R1", "pins after reset", int'({nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe}), 6);
    check(rsp_valid === 1'b0 && rb_rise_flag === 1'b0, "R1", "rsp_valid/flag after reset",
          int'({rsp_valid, rb_rise_flag}), 0);

    // Sweep all phase lengths 0..3 for every kind
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++)
        for (int h = 0; h < 4; h++)
          for (int k = 0; k < 4; k++)
            run_cycle(k, BW'(s * 16 + w * 4 + h + k * 64 + 5), s, w, h);

    // Ready/busy: falling edge
    @(negedge clk); nand_rb = 1'b0;
    @(negedge clk);
    check(rb_level === 1'b1, "R10", "level one edge after fall", int'(rb_level), 1);
    @(negedge clk);
    check(rb_level === 1'b0, "R10", "level two edges after fall", int'(rb_level), 0);
    @(negedge clk);
    check(rb_rise_flag === 1'b0, "R11", "fall does not set flag", int'(rb_rise_flag), 0);
    // Rising edge, clear in the same clock as the rise
    nand_rb = 1'b1;
    @(negedge clk);
    check(rb_level === 1'b0, "R10", "level one edge after rise", int'(rb_level), 0);
    @(negedge clk);
    check(rb_level === 1'b1 && rb_rise_flag === 1'b0, "R10", "level two edges after rise",
          int'({rb_level, rb_rise_flag}), 2);
    rb_flag_clr = 1'b1;
    @(negedge clk);
    rb_flag_clr = 1'b0;
    check(rb_rise_flag === 1'b1, "R12", "rise wins over simultaneous clear", int'(rb_rise_flag), 1);
    repeat (3) @(negedge clk);
    check(rb_rise_flag === 1'b1, "R11", "flag sticky", int'(rb_rise_flag), 1);
    rb_flag_clr = 1'b1;
    @(negedge clk);
    rb_flag_clr = 1'b0;
    check(rb_rise_flag === 1'b0, "R12", "clear pulse clears flag", int'(rb_rise_flag), 0);
    @(negedge clk);
    check(rb_rise_flag === 1'b0, "R12", "flag stays clear", int'(rb_rise_flag), 0);
    // Second busy period, no clear
    nand_rb = 1'b0;
    repeat (4) @(negedge clk);
    nand_rb = 1'b1;
    repeat (2) @(negedge clk);
    check(rb_rise_flag === 1'b0, "R11", "flag not yet set at level rise", int'(rb_rise_flag), 0);
    @(negedge clk);
    check(rb_rise_flag === 1'b1, "R11", "flag set edge after level rise", int'(rb_rise_flag), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule